// File: doc/BRIEF.md
# Phase-Shift Keying Carrier Modulator

This block produces a digital sinusoidal carrier and keys its phase from a serial bit stream. A 32-bit phase accumulator adds a frequency tuning word on every clock. Its upper eight bits address a single sine table that spans exactly one carrier period. Phase shifts come from adding a two-bit offset code to the top two address bits before the lookup, so the design has no multiplier and no second table.

In two-phase mode each received bit selects the plain carrier or its half-cycle shifted copy. In four-phase mode bits are paired, Gray mapped, and select one of four carriers spaced a quarter cycle apart. A new symbol is applied only when the accumulator wraps, which is the carrier cycle boundary. Data that arrives earlier waits in a one-symbol holding register. The registered signed sample bus drives an external DAC.

Top module: `psk_dds_mod`

## Requirements
- R1: The phase accumulator resets to zero and adds `tune_word` modulo 2^32 on every clock.
- R2: The table address is accumulator bits [31:24] plus 64 times the active offset code, modulo 256. Code 0 is 0 degrees, code 1 is 90 degrees, code 2 is 180 degrees and code 3 is 270 degrees.
- R3: `sample_out` is round(127*sin(2*pi*addr/256)) in 8-bit two's complement, with halves rounded away from zero. It is registered: the value after a clock edge comes from the accumulator and code held before that edge. It never takes the value -128.
- R4: When `mode_sel` is 0 (two-phase mode), a received bit 0 forms a symbol with code 0, and a bit 1 forms a symbol with code 2.
- R5: When `mode_sel` is 1 (four-phase mode), two received bits form one symbol, and the first bit is the more significant. Pair 00 maps to code 0, 01 to code 1, 11 to code 2 and 10 to code 3.
- R6: A wrap is a carry out of the accumulator addition. At a wrap edge, the most recently completed symbol from earlier cycles becomes the active code. A symbol completed on the wrap edge itself waits for the next wrap.
- R7: At a wrap with no symbol waiting, the active code is unchanged. Between wraps the code never changes.
- R8: `mode_sel` is sampled only at wrap edges. Changes between wraps have no effect on grouping or mapping.
- R9: When the sampled mode changes at a wrap, a half-collected pair is discarded, and so is any bit presented in that cycle.
- R10: During and right after reset, `sample_out` is 0, the active code is 0, two-phase mode is active and no symbol is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tune_word | input | 32 | Phase increment per clock |
| bit_in | input | 1 | Serial data bit |
| bit_valid | input | 1 | Qualifies `bit_in` for this cycle |
| mode_sel | input | 1 | 0 two-phase, 1 four-phase (sampled at wraps) |
| sample_out | output | 8 | Signed carrier sample for the DAC |

## Verification
The hardest case to reach from the ports is a mode change on the exact clock where the accumulator wraps while a pair is half collected, possibly with a bit arriving in that same cycle. The stimulus uses a tuning word of all ones, which makes nearly every cycle a wrap. It also toggles the mode at random inside dense bit traffic, so these coincidences happen many times. Other phases use a zero tuning word, which never wraps, and a slow word that walks every table address twice. These cover symbols held indefinitely and every table entry.

// File: rtl/psk_pkg.sv
package psk_pkg;
  localparam int ADDR_W = 8;
  localparam int SAMP_W = 8;
  localparam int QTR_W  = ADDR_W - 2;

  typedef logic [1:0] phase_code_t;

  // first quarter of a sine period, amplitude 127; index 64 is the peak
  function automatic logic [6:0] quarter_sine(input logic [QTR_W:0] i);
    logic [6:0] v;
    if (i[QTR_W]) begin
      v = 7'd127;
    end else begin
      case (i[QTR_W-1:0])
        6'd0:  v = 7'd0;   6'd1:  v = 7'd3;   6'd2:  v = 7'd6;   6'd3:  v = 7'd9;
        6'd4:  v = 7'd12;  6'd5:  v = 7'd16;  6'd6:  v = 7'd19;  6'd7:  v = 7'd22;
        6'd8:  v = 7'd25;  6'd9:  v = 7'd28;  6'd10: v = 7'd31;  6'd11: v = 7'd34;
        6'd12: v = 7'd37;  6'd13: v = 7'd40;  6'd14: v = 7'd43;  6'd15: v = 7'd46;
        6'd16: v = 7'd49;  6'd17: v = 7'd51;  6'd18: v = 7'd54;  6'd19: v = 7'd57;
        6'd20: v = 7'd60;  6'd21: v = 7'd63;  6'd22: v = 7'd65;  6'd23: v = 7'd68;
        6'd24: v = 7'd71;  6'd25: v = 7'd73;  6'd26: v = 7'd76;  6'd27: v = 7'd78;
        6'd28: v = 7'd81;  6'd29: v = 7'd83;  6'd30: v = 7'd85;  6'd31: v = 7'd88;
        6'd32: v = 7'd90;  6'd33: v = 7'd92;  6'd34: v = 7'd94;  6'd35: v = 7'd96;
        6'd36: v = 7'd98;  6'd37: v = 7'd100; 6'd38: v = 7'd102; 6'd39: v = 7'd104;
        6'd40: v = 7'd106; 6'd41: v = 7'd107; 6'd42: v = 7'd109; 6'd43: v = 7'd111;
        6'd44: v = 7'd112; 6'd45: v = 7'd113; 6'd46: v = 7'd115; 6'd47: v = 7'd116;
        6'd48: v = 7'd117; 6'd49: v = 7'd118; 6'd50: v = 7'd120; 6'd51: v = 7'd121;
        6'd52: v = 7'd122; 6'd53: v = 7'd122; 6'd54: v = 7'd123; 6'd55: v = 7'd124;
        6'd56: v = 7'd125; 6'd57: v = 7'd125; 6'd58: v = 7'd126; 6'd59: v = 7'd126;
        6'd60: v = 7'd126; 6'd61: v = 7'd127; 6'd62: v = 7'd127; default: v = 7'd127;
      endcase
    end
    return v;
  endfunction

  // full period by quadrant mirroring of the quarter table
  function automatic logic signed [SAMP_W-1:0] full_sine(input logic [ADDR_W-1:0] a);
    logic [QTR_W:0]  idx;
    logic [6:0]      mag;
    logic [SAMP_W-1:0] pos;
    idx = a[ADDR_W-2] ? ((QTR_W+1)'(1 << QTR_W) - {1'b0, a[QTR_W-1:0]})
                      : {1'b0, a[QTR_W-1:0]};
    mag = quarter_sine(idx);
    pos = {1'b0, mag};
    return a[ADDR_W-1] ? -pos : pos;
  endfunction
endpackage

// File: rtl/psk_phase_acc.sv
module psk_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] tune,
  output logic [ACC_W-1:0] acc_q,
  output logic             wrap
);
  logic [ACC_W-1:0] acc_n;

  always_comb begin
    {wrap, acc_n} = {1'b0, acc_q} + {1'b0, tune};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_n;
  end
endmodule

// File: rtl/psk_symbol_collect.sv
module psk_symbol_collect
  import psk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_in,
  input  logic        bit_valid,
  input  logic        mode_in,
  input  logic        wrap,
  output phase_code_t code_q,
  output logic        mode_q,
  output logic        half_q
);
  logic        first_q, pend_q;
  phase_code_t pend_code_q;

  logic        mode_chg, take, sym_done;
  phase_code_t sym_code;
  logic        first_n, half_n, pend_n, mode_n;
  phase_code_t pend_code_n, code_n;

  always_comb begin
    mode_chg = wrap && (mode_in != mode_q);
    take     = bit_valid && !mode_chg;
    if (mode_q) begin
      sym_done = take && half_q;
      sym_code = {first_q, first_q ^ bit_in};  // Gray pair mapping
    end else begin
      sym_done = take;
      sym_code = {bit_in, 1'b0};
    end
    half_n      = mode_chg ? 1'b0 : ((take && mode_q) ? ~half_q : half_q);
    first_n     = (take && mode_q && !half_q) ? bit_in : first_q;
    code_n      = (wrap && pend_q) ? pend_code_q : code_q;
    pend_n      = sym_done ? 1'b1 : (wrap ? 1'b0 : pend_q);
    pend_code_n = sym_done ? sym_code : pend_code_q;
    mode_n      = wrap ? mode_in : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q      <= '0;
      mode_q      <= 1'b0;
      half_q      <= 1'b0;
      first_q     <= 1'b0;
      pend_q      <= 1'b0;
      pend_code_q <= '0;
    end else begin
      code_q      <= code_n;
      mode_q      <= mode_n;
      half_q      <= half_n;
      first_q     <= first_n;
      pend_q      <= pend_n;
      pend_code_q <= pend_code_n;
    end
  end
endmodule

// File: rtl/psk_sine_out.sv
module psk_sine_out
  import psk_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        phase,
  input  phase_code_t              code,
  output logic signed [SAMP_W-1:0] sample_q
);
  logic [ADDR_W-1:0]        addr;
  logic signed [SAMP_W-1:0] sample_n;

  always_comb begin
    addr     = phase + {code, {(ADDR_W-2){1'b0}}};
    sample_n = full_sine(addr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample_q <= '0;
    else        sample_q <= sample_n;
  end
endmodule

// File: rtl/psk_dds_mod.sv
module psk_dds_mod
  import psk_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ACC_W-1:0]         tune_word,
  input  logic                     bit_in,
  input  logic                     bit_valid,
  input  logic                     mode_sel,
  output logic signed [SAMP_W-1:0] sample_out
);
  logic [ACC_W-1:0] acc_q;
  logic             wrap;
  phase_code_t      code_q;
  logic             mode_q, half_q;

  psk_phase_acc #(.ACC_W(ACC_W)) acc_i (
    .clk(clk), .rst_n(rst_n), .tune(tune_word), .acc_q(acc_q), .wrap(wrap)
  );

  psk_symbol_collect sym_i (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_valid(bit_valid),
    .mode_in(mode_sel), .wrap(wrap), .code_q(code_q), .mode_q(mode_q),
    .half_q(half_q)
  );

  psk_sine_out out_i (
    .clk(clk), .rst_n(rst_n), .phase(acc_q[ACC_W-1 -: ADDR_W]), .code(code_q),
    .sample_q(sample_out)
  );
endmodule

// File: rtl/psk_dds_mod_chk.sv
module psk_dds_mod_chk #(
  parameter int ACC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ACC_W-1:0] tune_word,
  input logic             mode_sel,
  input logic [ACC_W-1:0] acc_q,
  input logic             wrap,
  input logic [1:0]       code_q,
  input logic             mode_q,
  input logic             half_q,
  input logic [7:0]       sample_out
);
  assert_acc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> acc_q == $past(acc_q) + $past(tune_word));

  assert_no_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_out != 8'h80);

  assert_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(code_q));

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(mode_q));

  assert_pair_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && (mode_sel != mode_q)) |=> !half_q);
endmodule

bind psk_dds_mod psk_dds_mod_chk #(.ACC_W(ACC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tune_word(tune_word), .mode_sel(mode_sel),
  .acc_q(acc_q), .wrap(wrap), .code_q(code_q), .mode_q(mode_q),
  .half_q(half_q), .sample_out(sample_out)
);

// File: tb/psk_dds_mod_tb.sv
module psk_dds_mod_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tune_word = '0;
  logic        bit_in = 1'b0;
  logic        bit_valid = 1'b0;
  logic        mode_sel = 1'b0;
  logic signed [7:0] sample_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  string cur_req = "R10";

  always #10 clk = ~clk;  // 50 MHz

  psk_dds_mod dut_i (
    .clk(clk), .rst_n(rst_n), .tune_word(tune_word), .bit_in(bit_in),
    .bit_valid(bit_valid), .mode_sel(mode_sel), .sample_out(sample_out)
  );

  // reference sine, R3 rounding
  function automatic int sine_ref(int a);
    real v;
    v = 127.0 * $sin(2.0 * 3.14159265358979 * a / 256.0);
    if (v >= 0.0) return $rtoi(v + 0.5);
    else          return -$rtoi(-v + 0.5);
  endfunction

  // reference state built from the requirements
  longint unsigned m_acc;
  int  m_code, m_sample, m_pend_code, m_first;
  bit  m_mode, m_half, m_pend;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0; m_code = 0; m_sample = 0; m_mode = 0; m_half = 0;
      m_pend = 0; m_pend_code = 0; m_first = 0;
    end else begin
      bit wrap, chg, take, done_sym;
      int scode;
      longint unsigned sum;
      m_sample = sine_ref(int'(((m_acc >> 24) + 64 * m_code) % 256));
      sum  = m_acc + tune_word;
      wrap = sum >= 64'h1_0000_0000;
      chg  = wrap && (mode_sel != m_mode);
      take = bit_valid && !chg;
      done_sym = 0; scode = 0;
      if (take) begin
        if (!m_mode) begin
          done_sym = 1; scode = bit_in ? 2 : 0;
        end else if (m_half) begin
          done_sym = 1;
          case ({m_first[0], bit_in})
            2'b00: scode = 0; 2'b01: scode = 1;
            2'b11: scode = 2; default: scode = 3;
          endcase
          m_half = 0;
        end else begin
          m_first = int'(bit_in); m_half = 1;
        end
      end
      if (chg) m_half = 0;
      if (wrap && m_pend) m_code = m_pend_code;
      if (wrap) begin m_pend = 0; m_mode = mode_sel; end
      if (done_sym) begin m_pend = 1; m_pend_code = scode; end
      m_acc = sum % 64'h1_0000_0000;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (int'(sample_out) != m_sample) begin
        errors++;
        $display("FAIL %s sample=%0d expected=%0d", cur_req, sample_out, m_sample);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drive(int n, int pv, int pflip);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_valid = ($urandom % 100) < pv;
      bit_in    = $urandom % 2;
      if (($urandom % 100) < pflip) mode_sel = ~mode_sel;
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    // R10: reset state
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    drive(20, 0, 0);                 // tune 0: output stays at reset value
    cur_req = "R1";
    tune_word = 32'h0400_0000;
    drive(300, 0, 0);
    cur_req = "R4";
    drive(3000, 5, 0);
    cur_req = "R6";                  // dense bits: latest symbol wins
    drive(2000, 60, 0);
    cur_req = "R5";
    @(negedge clk); mode_sel = 1'b1;
    drive(4000, 8, 0);
    cur_req = "R2";
    tune_word = 32'h0080_0000;       // every address visited twice
    drive(4000, 2, 0);
    cur_req = "R3";
    for (int k = 0; k < 8; k++) begin
      tune_word = $urandom;
      drive(500, 10, 0);
    end
    cur_req = "R7";
    tune_word = 32'h0;
    drive(500, 30, 0);
    cur_req = "R8";
    tune_word = 32'h0200_0000;
    drive(3000, 10, 3);
    cur_req = "R9";
    tune_word = 32'hFFFF_FFFF;       // nearly every cycle wraps
    drive(3000, 50, 20);
    tune_word = 32'h0100_0000;
    drive(3000, 20, 2);
    cur_req = "R10";
    @(negedge clk); rst_n = 1'b0;
    drive(5, 0, 0);
    @(negedge clk); rst_n = 1'b1; tune_word = 32'h0;
    drive(10, 0, 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule